// File: doc/BRIEF.md
# Two-Phase Fetch/Execute Sequencer

This block sequences a small processor whose instructions and data live in one single-ported memory. A one-bit phase register alternates between an instruction-fetch cycle and an execute cycle. That register decides which address source the memory sees and which datapath registers may change. Every instruction therefore costs two clock cycles, and the fetch never competes with a load or store for the memory port.

In the fetch cycle the memory is addressed by the program counter and the instruction register captures the read data. In the execute cycle the memory is addressed by the ALU result. The program counter advances, either to the next sequential address or to a branch/jump target. The memory-write and register-file-write requests of the current instruction class are passed on only in that execute cycle. The program counter register lives inside the block. The target address and the zero flag come from the surrounding datapath.

Top module: `fxc_sequencer`

## Requirements
- R1: After reset the phase output is 0 (fetch). While `run_en` is high, the phase flips on every rising clock edge (0 = fetch, 1 = execute).
- R2: In a fetch cycle `addr_sel` is 0 (memory address from the PC) and `ir_load` is 1 when running. `pc_load`, `rf_we` and `mem_we` are 0 whatever the instruction class is.
- R3: In an execute cycle `addr_sel` is 1 (memory address from the ALU), `ir_load` is 0 and `pc_load` is 1 when running.
- R4: At the end of an execute cycle the PC loads `target` if the class is jump (4), or if the class is branch (3) and the branch condition holds. The condition holds when `zero_flag` is 1 with `BRANCH_ON_ZERO`=1, and when it is 0 with `BRANCH_ON_ZERO`=0. Otherwise the PC loads PC+`PC_STEP`, wrapping modulo 2^`ADDR_W`.
- R5: `mem_we` is 1 only in a running execute cycle whose class is store (2).
- R6: `rf_we` is 1 only in a running execute cycle whose class is ALU (0) or load (1). Class codes 5 to 7 request no writes and step the PC sequentially.
- R7: The PC changes at most once every two cycles. A run of N non-redirecting instructions advances it by N*`PC_STEP` in 2N cycles.
- R8: While `rst_n` is low, the phase is fetch, `pc` equals `RESET_PC` (default 0) and `ir_load`, `pc_load`, `rf_we` and `mem_we` are all 0.
- R9: While `run_en` is low, the phase and `pc` hold their values and `ir_load`, `pc_load`, `rf_we` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Sequencer advances when high |
| iclass | input | 3 | Decoded instruction class: 0 ALU, 1 load, 2 store, 3 branch, 4 jump |
| zero_flag | input | 1 | ALU zero result, used by branches |
| target | input | ADDR_W | Branch or jump destination |
| phase | output | 1 | 0 fetch, 1 execute |
| addr_sel | output | 1 | Memory address select: 0 PC, 1 ALU result |
| ir_load | output | 1 | Instruction register load enable |
| pc_load | output | 1 | Program counter load enable |
| rf_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Memory write enable |
| pc | output | ADDR_W | Current program counter |

## Verification
The bench builds the sequencer with `ADDR_W`=16, `PC_STEP`=4, `RESET_PC`=0 and `BRANCH_ON_ZERO`=1. The narrow address lets a jump to 0xFFFC followed by a sequential step show the PC wrapping to zero. The scoreboard models phase and PC on its own and compares every cycle. Its stimulus covers reset asserted with a store pending, a halt in the middle of an instruction, and branches both taken and not taken.

// File: rtl/fxc_pkg.sv
package fxc_pkg;

   typedef enum logic [2:0] {
      IC_ALU    = 3'd0,
      IC_LOAD   = 3'd1,
      IC_STORE  = 3'd2,
      IC_BRANCH = 3'd3,
      IC_JUMP   = 3'd4
   } iclass_e;

   typedef enum logic {
      PH_FETCH = 1'b0,
      PH_EXEC  = 1'b1
   } phase_e;

   typedef enum logic {
      AS_PC  = 1'b0,
      AS_ALU = 1'b1
   } asel_e;

   typedef struct packed {
      logic mem_wr;
      logic rf_wr;
      logic redirect;
   } req_t;

endpackage

// File: rtl/fxc_phase.sv
module fxc_phase
   import fxc_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   advance,
   output phase_e phase_o
);

   phase_e phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_FETCH;
      end else if (advance) begin
         phase_q <= (phase_q == PH_FETCH) ? PH_EXEC : PH_FETCH;
      end
   end

   assign phase_o = phase_q;

   // R1: phase flips on every advancing edge
   a_r1_phase_flips: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (phase_o != $past(phase_o)));

   // R9: phase holds when not advancing
   a_r9_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(phase_o));

endmodule

// File: rtl/fxc_decode.sv
module fxc_decode
   import fxc_pkg::*;
#(
   parameter bit BRANCH_ON_ZERO = 1'b1
)(
   input  logic [2:0] iclass_i,
   input  logic       zero_i,
   output req_t       req_o
);

   logic cond_met;

   generate
      if (BRANCH_ON_ZERO) begin : g_br_zero
         assign cond_met = zero_i;
      end else begin : g_br_nonzero
         assign cond_met = ~zero_i;
      end
   endgenerate

   always_comb begin
      req_o = '0;
      unique case (iclass_i)
         IC_ALU:    req_o.rf_wr    = 1'b1;
         IC_LOAD:   req_o.rf_wr    = 1'b1;
         IC_STORE:  req_o.mem_wr   = 1'b1;
         IC_BRANCH: req_o.redirect = cond_met;
         IC_JUMP:   req_o.redirect = 1'b1;
         default:   req_o          = '0;
      endcase
   end

   // R5/R6: at most one write kind per class
   always_comb begin
      a_r6_one_write_kind: assert ($onehot0({req_o.mem_wr, req_o.rf_wr}));
   end

endmodule

// File: rtl/fxc_pc.sv
module fxc_pc #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned PC_STEP  = 4,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              redirect,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] pc_o
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] seq_pc;
   logic [ADDR_W-1:0] nxt_pc;

   assign seq_pc = pc_q + STEP;
   assign nxt_pc = redirect ? target : seq_pc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= RESET_PC;
      end else if (load) begin
         pc_q <= nxt_pc;
      end
   end

   assign pc_o = pc_q;

   // R4: redirect takes the target
   a_r4_redirect_target: assert property (@(posedge clk) disable iff (!rst_n)
      (load && redirect) |=> (pc_o == $past(target)));

   // R9: no load, no change
   a_r9_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(pc_o));

endmodule

// File: rtl/fxc_sequencer.sv
module fxc_sequencer
   import fxc_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned PC_STEP        = 4,
   parameter logic [ADDR_W-1:0] RESET_PC = '0,
   parameter bit          BRANCH_ON_ZERO = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic [2:0]        iclass,
   input  logic              zero_flag,
   input  logic [ADDR_W-1:0] target,
   output logic              phase,
   output logic              addr_sel,
   output logic              ir_load,
   output logic              pc_load,
   output logic              rf_we,
   output logic              mem_we,
   output logic [ADDR_W-1:0] pc
);

   generate
      if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_width
         $error("fxc_sequencer: ADDR_W out of range");
      end
      if (PC_STEP == 0 || (PC_STEP & (PC_STEP - 1)) != 0) begin : g_bad_step
         $error("fxc_sequencer: PC_STEP must be a power of two");
      end
   endgenerate

   phase_e ph;
   req_t   req;
   logic   active;
   logic   in_exec;

   assign active  = run_en & rst_n;

   fxc_phase u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (active),
      .phase_o (ph)
   );

   fxc_decode #(
      .BRANCH_ON_ZERO (BRANCH_ON_ZERO)
   ) u_decode (
      .iclass_i (iclass),
      .zero_i   (zero_flag),
      .req_o    (req)
   );

   assign in_exec = (ph == PH_EXEC);

   always_comb begin
      addr_sel = in_exec ? AS_ALU : AS_PC;
      ir_load  = active & ~in_exec;
      pc_load  = active &  in_exec;
      rf_we    = pc_load & req.rf_wr;
      mem_we   = pc_load & req.mem_wr;
   end

   fxc_pc #(
      .ADDR_W   (ADDR_W),
      .PC_STEP  (PC_STEP),
      .RESET_PC (RESET_PC)
   ) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pc_load),
      .redirect (req.redirect),
      .target   (target),
      .pc_o     (pc)
   );

   assign phase = ph;

   // R2: fetch cycles never write
   a_r2_fetch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_FETCH) |-> (!pc_load && !rf_we && !mem_we));

   // R3: execute cycles never load the instruction register
   a_r3_exec_no_ir: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EXEC) |-> !ir_load);

   // R5: memory write only for a store in execute
   a_r5_store_only: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (phase == PH_EXEC && iclass == IC_STORE && run_en));

   // R6: register write only for ALU/load
   a_r6_rf_classes: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (iclass == IC_ALU || iclass == IC_LOAD));

   // R7: PC never changes across a fetch cycle
   a_r7_pc_stable_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_FETCH) |=> $stable(pc));

   // R9: halted means no enables
   a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |-> !(ir_load || pc_load || rf_we || mem_we));

endmodule

// File: tb/fxc_sequencer_tb.sv
module fxc_sequencer_tb;

   localparam int AW = 16;

   typedef struct {
      logic          ph;
      logic          sel;
      logic          ir;
      logic          pcl;
      logic          rf;
      logic          mw;
      logic [AW-1:0] pc;
      string         req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_en = 1'b0;
   logic [2:0]    iclass = 3'd0;
   logic          zero_flag = 1'b0;
   logic [AW-1:0] target = '0;
   logic          phase, addr_sel, ir_load, pc_load, rf_we, mem_we;
   logic [AW-1:0] pc;

   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t q[$];

   logic          m_ph = 1'b0;
   logic [AW-1:0] m_pc = '0;

   always #5 clk = ~clk;

   fxc_sequencer #(
      .ADDR_W (AW), .PC_STEP (4), .RESET_PC ('0), .BRANCH_ON_ZERO (1'b1)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .run_en (run_en), .iclass (iclass),
      .zero_flag (zero_flag), .target (target), .phase (phase),
      .addr_sel (addr_sel), .ir_load (ir_load), .pc_load (pc_load),
      .rf_we (rf_we), .mem_we (mem_we), .pc (pc)
   );

   task automatic step(input logic rst, input logic run, input logic [2:0] cls,
                       input logic z, input logic [AW-1:0] tgt, input string req);
      exp_t e;
      logic en, taken;
      @(posedge clk);
      #1;
      rst_n = rst; run_en = run; iclass = cls; zero_flag = z; target = tgt;
      if (!rst) begin m_ph = 1'b0; m_pc = '0; end
      en     = rst & run;
      taken  = (cls == 3'd4) || (cls == 3'd3 && z);
      e.ph   = m_ph;
      e.sel  = m_ph;
      e.ir   = en & ~m_ph;
      e.pcl  = en & m_ph;
      e.rf   = e.pcl & (cls == 3'd0 || cls == 3'd1);
      e.mw   = e.pcl & (cls == 3'd2);
      e.pc   = m_pc;
      e.req  = req;
      q.push_back(e);
      if (en) begin
         if (m_ph) m_pc = taken ? tgt : m_pc + 16'd4;
         m_ph = ~m_ph;
      end
   endtask

   // one instruction: fetch cycle offers a store class to prove gating (R2)
   task automatic instr(input logic [2:0] cls, input logic z,
                        input logic [AW-1:0] tgt, input string req);
      step(1'b1, 1'b1, 3'd2, 1'b1, 16'h0BAD, "R2");
      step(1'b1, 1'b1, cls, z, tgt, req);
   endtask

   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_run++;
         if ({phase, addr_sel, ir_load, pc_load, rf_we, mem_we, pc} !==
             {e.ph, e.sel, e.ir, e.pcl, e.rf, e.mw, e.pc}) begin
            n_fail++;
            $display("FAIL %s: got ph=%b sel=%b ir=%b pcl=%b rf=%b mw=%b pc=%h exp ph=%b sel=%b ir=%b pcl=%b rf=%b mw=%b pc=%h",
                     e.req, phase, addr_sel, ir_load, pc_load, rf_we, mem_we, pc,
                     e.ph, e.sel, e.ir, e.pcl, e.rf, e.mw, e.pc);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
   end

   initial begin
      logic [AW-1:0] start;
      // R8: reset with run enabled and store class pending
      step(1'b0, 1'b1, 3'd2, 1'b0, '0, "R8");
      step(1'b0, 1'b1, 3'd0, 1'b0, '0, "R8");
      // R1/R3/R6: ALU and load write back
      instr(3'd0, 1'b0, '0, "R6");
      instr(3'd1, 1'b0, '0, "R6");
      // R5: store writes memory
      instr(3'd2, 1'b0, '0, "R5");
      // R4: branch taken and not taken
      instr(3'd3, 1'b1, 16'h0040, "R4");
      instr(3'd3, 1'b0, 16'h0100, "R4");
      // R6: unused class code 6 is a no-op
      instr(3'd6, 1'b0, 16'h0200, "R6");
      // R4: jump to top, then sequential wrap to zero
      instr(3'd4, 1'b0, 16'hFFFC, "R4");
      instr(3'd0, 1'b0, '0, "R4");
      // R9: halt in fetch, then halt in execute with a store pending
      step(1'b1, 1'b0, 3'd2, 1'b0, '0, "R9");
      step(1'b1, 1'b0, 3'd2, 1'b0, '0, "R9");
      step(1'b1, 1'b1, 3'd0, 1'b0, '0, "R1");
      step(1'b1, 1'b0, 3'd2, 1'b1, 16'h0300, "R9");
      step(1'b1, 1'b0, 3'd4, 1'b1, 16'h0300, "R9");
      step(1'b1, 1'b1, 3'd1, 1'b0, '0, "R3");
      // R7: four sequential instructions advance by 16 in 8 cycles
      start = m_pc;
      for (int i = 0; i < 4; i++) instr(3'd0, 1'b0, '0, "R7");
      step(1'b1, 1'b0, 3'd0, 1'b0, '0, "R9");
      @(negedge clk);
      n_run++;
      if (pc !== start + 16'd16) begin
         n_fail++;
         $display("FAIL R7: got pc=%h exp %h", pc, start + 16'd16);
      end
      // R8: reset in mid-instruction returns to fetch at zero
      step(1'b1, 1'b1, 3'd0, 1'b0, '0, "R1");
      step(1'b0, 1'b1, 3'd2, 1'b0, '0, "R8");
      instr(3'd2, 1'b0, '0, "R5");
      @(posedge clk);
      @(posedge clk);
      while (q.size() > 0) @(posedge clk);
      finish_run();
   end

endmodule